// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block collects event indications from a clock and power manager and turns them into one interrupt request. Seven live inputs are monitored: two PLL lock flags, three oscillator-ready flags, a clock-gating-ready flag and a brown-out detect. A 0-to-1 change on any of them latches a sticky pending bit, and that bit stays set until software clears it. An eighth status bit, clock-ready, is a level. A clock-selection write pulse drops it and a switch-done pulse raises it again.

Software reaches the block through a plain single-cycle register port. A word index selects one of five 32-bit registers: an enable register and a disable register (both write-one) that change the interrupt mask, a read-only mask view, a read-only status view, and a write-one-to-clear register for the sticky bits. The interrupt output is high whenever an enabled status bit is set.

Top module: `pwr_irq_status`

## Requirements
- R1: After reset, status reads 0x0000_0020 (only clock-ready set), mask reads 0 and `irq` is 0.
- R2: Register word indices are: 0 enable, 1 disable, 2 mask (read), 3 status (read), 4 clear. A read of index 0, 1, 4 or any unused index returns 0. Reserved bit positions always read 0.
- R3: A rising edge on an event input sets its status bit. Bit positions: `lock_a` 0, `lock_b` 1, `gate_rdy` 6, `osc_main_rdy` 7, `osc_aux_rdy` 8, `osc_slow_rdy` 9, `brownout` 16. The bit reads 1 after the clock edge that samples the input high for the first time.
- R4: A pending bit stays set while its input falls or stays high. An input held high does not set the bit again after it has been cleared.
- R5: Writing 1 to a bit of the clear register (index 4) clears that pending bit on the write edge, and writing 0 leaves it unchanged. A rising edge in the same cycle as the clear keeps the bit set.
- R6: Writing 1 to a bit of the enable register (index 0) sets that mask bit, and writing 1 to a bit of the disable register (index 1) clears it. Only bits 0, 1, 5, 6, 7, 8, 9 and 16 are kept in the mask.
- R7: The clock-ready status bit (bit 5) reads 0 after a `clksel_wr` pulse and reads 1 after a `clksw_done` pulse. When both pulses come together, the bit reads 0. Writing 1 to bit 5 of the clear register has no effect.
- R8: `irq` equals the OR over all bits of (status AND mask), and it follows the registered state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_a | input | 1 | First PLL lock flag (live) |
| lock_b | input | 1 | Second PLL lock flag (live) |
| gate_rdy | input | 1 | Clock gating applied flag (live) |
| osc_main_rdy | input | 1 | Main oscillator stable (live) |
| osc_aux_rdy | input | 1 | Auxiliary oscillator stable (live) |
| osc_slow_rdy | input | 1 | Slow crystal oscillator stable (live) |
| brownout | input | 1 | Supply below brown-out threshold (live) |
| clksel_wr | input | 1 | One-cycle pulse: a new clock selection was written |
| clksw_done | input | 1 | One-cycle pulse: clocks now match the selection |
| reg_sel | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 write, 0 read |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational during a read |
| irq | output | 1 | Combined interrupt request |

## Verification
The edge assertions take the live inputs to be synchronous to `clk`. They also take the inputs to be low through reset, so that the first cycle after reset cannot produce a false edge. The stimulus changes inputs only on the falling clock edge and keeps every event input at 0 while reset is high. The mask properties assume at most one bus write per cycle, because the port allows only one. Enable and disable therefore never meet on the same edge in the bench.

// File: rtl/pwr_irq_pkg.sv
package pwr_irq_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int N_EV   = 7;

  localparam logic [IDX_W-1:0] IDX_ENA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_DIS = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MSK = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STA = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CLR = 3'd4;

  // event order: lock_a, lock_b, gate_rdy, osc_main, osc_aux, osc_slow, brownout
  localparam int EV_POS [N_EV] = '{0, 1, 6, 7, 8, 9, 16};
  localparam int CK_POS = 5;

  function automatic logic [DATA_W-1:0] impl_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_EV; i++) m[EV_POS[i]] = 1'b1;
    m[CK_POS] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK = impl_bits();
endpackage

// File: rtl/pwr_irq_sticky.sv
module pwr_irq_sticky #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] live,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    assign rise = live[i] & ~prev[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i] <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        prev[i] <= live[i];
        if (rise)        pend[i] <= 1'b1;
        else if (clr[i]) pend[i] <= 1'b0;
      end
    end

    // R3: an edge always latches
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (rst)
      (live[i] && !prev[i]) |=> pend[i]);
    // R4: pending holds without a clear
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr[i]) |=> pend[i]);
    // R5: a clear with no competing edge empties the bit
    a_r5_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !(live[i] && !prev[i])) |=> !pend[i]);
  end
endmodule

// File: rtl/pwr_irq_mask.sv
module pwr_irq_mask
  import pwr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_bits,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= (mask | set_bits) & ~clr_bits & IMPL_MASK;
  end

  // R6: enabled bits appear in the mask
  a_r6_enable_sets: assert property (@(posedge clk) disable iff (rst)
    ((set_bits & ~clr_bits & IMPL_MASK) != '0) |=>
    ((mask & $past(set_bits & ~clr_bits & IMPL_MASK)) == $past(set_bits & ~clr_bits & IMPL_MASK)));
  // R6: disabled bits leave the mask
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_bits != '0) |=> ((mask & $past(clr_bits)) == '0));
endmodule

// File: rtl/pwr_irq_ckrdy.sv
module pwr_irq_ckrdy (
  input  logic clk,
  input  logic rst,
  input  logic sel_pulse,
  input  logic done_pulse,
  output logic ck_ok
);
  always_ff @(posedge clk) begin
    if (rst)             ck_ok <= 1'b1;
    else if (sel_pulse)  ck_ok <= 1'b0;
    else if (done_pulse) ck_ok <= 1'b1;
  end

  // R7: a new selection drops clock-ready
  a_r7_sel_drops: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |=> !ck_ok);
  // R7: completion raises clock-ready
  a_r7_done_raises: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && !sel_pulse) |=> ck_ok);
endmodule

// File: rtl/pwr_irq_status.sv
module pwr_irq_status
  import pwr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_a,
  input  logic              lock_b,
  input  logic              gate_rdy,
  input  logic              osc_main_rdy,
  input  logic              osc_aux_rdy,
  input  logic              osc_slow_rdy,
  input  logic              brownout,
  input  logic              clksel_wr,
  input  logic              clksw_done,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [N_EV-1:0]   ev_live, ev_clr, ev_pend;
  logic [DATA_W-1:0] stat_w, mask_w, ena_w, dis_w;
  logic              ck_ok, wr;

  assign ev_live = {brownout, osc_slow_rdy, osc_aux_rdy, osc_main_rdy,
                    gate_rdy, lock_b, lock_a};
  assign wr    = reg_sel & reg_we;
  assign ena_w = (wr && reg_idx == IDX_ENA) ? reg_wdata : '0;
  assign dis_w = (wr && reg_idx == IDX_DIS) ? reg_wdata : '0;

  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    assign ev_clr[i] = wr && (reg_idx == IDX_CLR) && reg_wdata[EV_POS[i]];
  end

  pwr_irq_sticky #(.N(N_EV)) u_sticky (
    .clk(clk), .rst(rst), .live(ev_live), .clr(ev_clr), .pend(ev_pend)
  );

  pwr_irq_mask u_mask (
    .clk(clk), .rst(rst), .set_bits(ena_w), .clr_bits(dis_w), .mask(mask_w)
  );

  pwr_irq_ckrdy u_ckrdy (
    .clk(clk), .rst(rst), .sel_pulse(clksel_wr), .done_pulse(clksw_done),
    .ck_ok(ck_ok)
  );

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < N_EV; i++) stat_w[EV_POS[i]] = ev_pend[i];
    stat_w[CK_POS] = ck_ok;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_we) begin
      case (reg_idx)
        IDX_MSK: reg_rdata = mask_w;
        IDX_STA: reg_rdata = stat_w;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq = |(stat_w & mask_w);

  // R2: reserved positions never read back as 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && !reg_we) |-> ((reg_rdata & ~IMPL_MASK) == '0));
  // R8: no request without an enabled source
  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    (mask_w == '0) |-> !irq);
endmodule

// File: tb/test_pwr_irq_status.sv
module test_pwr_irq_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0]  live = '0;
  logic        clksel_wr = 1'b0, clksw_done = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_irq_status i_pwr_irq_status (
    .clk(clk), .rst(rst),
    .lock_a(live[0]), .lock_b(live[1]), .gate_rdy(live[2]),
    .osc_main_rdy(live[3]), .osc_aux_rdy(live[4]), .osc_slow_rdy(live[5]),
    .brownout(live[6]), .clksel_wr(clksel_wr), .clksw_done(clksw_done),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [6:0]  live;
    logic        we;
    logic [2:0]  idx;
    logic [31:0] wd;
    logic [31:0] stat;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{7'b0000001, 1'b0, 3'd0, 32'h0,        32'h0000_0021, 1'b0},
    '{7'b0000001, 1'b1, 3'd0, 32'h1,        32'h0000_0021, 1'b1},
    '{7'b0000000, 1'b0, 3'd0, 32'h0,        32'h0000_0021, 1'b1},
    '{7'b0000000, 1'b1, 3'd4, 32'h21,       32'h0000_0020, 1'b0},
    '{7'b1000000, 1'b1, 3'd0, 32'h1_0000,   32'h0001_0020, 1'b1},
    '{7'b1100000, 1'b1, 3'd1, 32'h1_0000,   32'h0001_0220, 1'b0},
    '{7'b1111110, 1'b1, 3'd4, 32'h0,        32'h0001_03E2, 1'b0},
    '{7'b1111111, 1'b1, 3'd4, 32'h1,        32'h0001_03E3, 1'b1},
    '{7'b1111111, 1'b1, 3'd4, 32'hFFFF_FFFF,32'h0000_0020, 1'b0},
    '{7'b1111111, 1'b0, 3'd0, 32'h0,        32'h0000_0020, 1'b0},
    '{7'b0000000, 1'b1, 3'd0, 32'hFFFF_FFFF,32'h0000_0020, 1'b1},
    '{7'b0000000, 1'b1, 3'd1, 32'h20,       32'h0000_0020, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    reg_sel = 1'b1; reg_we = 1'b0; reg_idx = idx;
    #1 v = reg_rdata;
  endtask

  // one clock: drive at falling edge, leave bus idle-read afterwards
  task automatic step(input logic [6:0] lv, input logic we, input logic [2:0] idx,
                      input logic [31:0] wd, input logic sel_p, input logic done_p);
    @(negedge clk);
    live = lv; reg_sel = we; reg_we = we; reg_idx = idx; reg_wdata = wd;
    clksel_wr = sel_p; clksw_done = done_p;
    @(posedge clk);
    #2;
    reg_sel = 1'b0; reg_we = 1'b0; clksel_wr = 1'b0; clksw_done = 1'b0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #2;
    rd(3'd3, v); chk("R1 status after reset", v, 32'h20);
    rd(3'd2, v); chk("R1 mask after reset", v, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(3'd0, v); chk("R2 enable reads zero", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      step(TBL[k].live, TBL[k].we, TBL[k].idx, TBL[k].wd, 1'b0, 1'b0);
      rd(3'd3, v);
      chk($sformatf("R3/R4/R5 status vector %0d", k), v, TBL[k].stat);
      chk($sformatf("R6/R8 irq vector %0d", k), {31'b0, irq}, {31'b0, TBL[k].irq});
    end

    rd(3'd2, v); chk("R6 mask keeps implemented bits only", v, 32'h0001_03C3);
    rd(3'd4, v); chk("R2 clear reads zero", v, 32'h0);
    rd(3'd6, v); chk("R2 unused index reads zero", v, 32'h0);

    step(7'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    rd(3'd3, v); chk("R7 selection drops clock-ready", v, 32'h0);
    step(7'b0, 1'b1, 3'd4, 32'h20, 1'b0, 1'b0);
    rd(3'd3, v); chk("R7 clear has no effect low", v, 32'h0);
    step(7'b0, 1'b0, 3'd0, 32'h0, 1'b0, 1'b1);
    rd(3'd3, v); chk("R7 done raises clock-ready", v, 32'h20);
    step(7'b0, 1'b1, 3'd4, 32'h20, 1'b0, 1'b0);
    rd(3'd3, v); chk("R7 clear has no effect high", v, 32'h20);
    step(7'b0, 1'b1, 3'd0, 32'h20, 1'b0, 1'b0);
    chk("R8 irq from clock-ready", {31'b0, irq}, 32'h1);
    step(7'b0, 1'b0, 3'd0, 32'h0, 1'b1, 1'b1);
    rd(3'd3, v); chk("R7 selection beats done", v, 32'h0);
    chk("R8 irq follows clock-ready low", {31'b0, irq}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule